// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Pinned Entries

This block is a fully associative translation lookaside buffer. A lookup presents a virtual page number together with the current address-space identifier. The page number is compared against every stored entry at once, and the result (hit, physical frame number and permission bits) comes back combinationally in the same cycle. When a lookup misses, logic outside the block walks the page table. It then installs the translation through the fill port, so that the next reference to that page hits.

Every entry carries a valid bit, an address-space tag and a pinned ("wired") flag. Pinned entries hold translations that must stay resident, such as kernel mappings. A refill never replaces a pinned entry and an invalidation never clears one. A refill takes the lowest-index empty unpinned slot when one exists. Otherwise it takes the next unpinned slot in round-robin order. Invalidation clears either every unpinned entry or only the unpinned entries of one address space. If every slot is pinned, the refill is refused and a one-cycle flag reports it.

Top module: `tlb_asid_xlate`

## Requirements
- R1: A lookup compares the page number against all entries in parallel. On a hit it returns the stored frame number and permission bits in the same cycle. On a miss, frame and permission outputs are zero.
- R2: A hit requires both the stored page number and the stored address-space tag to equal the lookup inputs.
- R3: An entry whose valid bit is clear never hits. Reset clears every valid bit and every pinned flag.
- R4: An accepted fill writes its entry at the clock edge where fill_en is high. A lookup of that page and identifier in the following cycle hits with the filled frame and permissions.
- R5: While any unpinned entry is empty, a fill goes to the lowest-index empty unpinned entry, and valid entries are left untouched.
- R6: When every unpinned entry is valid, the victim is the first unpinned entry at or after a rotating pointer, wrapping at the last index. Every accepted fill moves the pointer to the entry after its victim. Reset sets the pointer to entry 0.
- R7: A pinned entry is never replaced by a fill and never cleared by an invalidation. pin_en with pin_set high pins entry pin_idx, and with pin_set low unpins it, at the clock edge.
- R8: inv_all clears the valid bit of every unpinned entry at the clock edge.
- R9: inv_asid_en clears only the unpinned entries whose tag equals inv_asid. Entries of other identifiers stay valid.
- R10: A fill requested while every entry is pinned writes nothing, and fill_full is high for exactly the one cycle that follows the request.
- R11: If several entries match a lookup, the lowest-index one supplies frame and permissions, and lk_multi is high. With a single match lk_multi is low.
- R12: When a fill and an invalidation fall on the same edge, the invalidation acts on the prior contents and the newly filled entry remains valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | PFN_W | Frame number of the hit entry, zero on miss |
| lk_perm | output | PERM_W | Permission bits of the hit entry, zero on miss |
| lk_multi | output | 1 | More than one entry matched |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Identifier to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_perm | input | PERM_W | Permission bits to install |
| fill_full | output | 1 | Previous fill refused, all entries pinned |
| pin_en | input | 1 | Update the pinned flag of one entry |
| pin_idx | input | IDX_W | Entry whose pinned flag is updated |
| pin_set | input | 1 | 1 pins, 0 unpins |
| inv_all | input | 1 | Clear all unpinned entries |
| inv_asid_en | input | 1 | Clear unpinned entries of one identifier |
| inv_asid | input | ASID_W | Identifier for the selective clear |

## Verification
Some properties are checked on every cycle. A pinned entry keeps its valid bit and tag from one cycle to the next unless its own pin flag is being changed. A global clear leaves no unpinned valid entry behind. A fill victim is never pinned, and when an empty slot exists the victim is always empty. fill_full only follows a fill request, and a multi-hit always comes with a hit. The bench's scenarios are needed for the rest. Only they can show which translation actually disappears under round-robin replacement, that tags of other identifiers survive a selective clear, lowest-index priority among duplicate entries, and the ordering of a fill and an invalidation on the same edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Index width that stays legal for a single-entry buffer
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IW    = tlb_pkg::idx_width(N)
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0][VPN_W-1:0]  vpn_tab,
  input  logic [N-1:0][ASID_W-1:0] asid_tab,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [ASID_W-1:0]        key_asid,
  output logic                     hit,
  output logic [IW-1:0]            hit_idx,
  output logic                     multi
);

  logic [N-1:0] match;

  // One comparator per entry, all evaluated at once
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = valid[i] && (vpn_tab[i] == key_vpn) && (asid_tab[i] == key_asid);
  end

  // Lowest index wins; a second match flags the conflict
  always_comb begin
    logic seen;
    seen    = 1'b0;
    multi   = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        if (seen) multi = 1'b1;
        else      hit_idx = IW'(i);
        seen = 1'b1;
      end
    end
  end

  assign hit = |match;

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int N   = 16,
  localparam int IW = tlb_pkg::idx_width(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  valid,
  input  logic [N-1:0]  wired,
  input  logic          fill_en,
  output logic          accept,
  output logic [IW-1:0] victim,
  output logic          fill_full
);

  logic [N-1:0]  cand;
  logic [N-1:0]  empty;
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] rr_idx;
  logic          has_free;

  assign cand     = ~wired;
  assign empty    = ~valid & ~wired;
  assign has_free = |empty;

  // Lowest-index empty unpinned slot
  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (empty[i]) free_idx = IW'(i);
    end
  end

  // First unpinned slot at or after the rotating pointer
  always_comb begin
    logic found;
    int unsigned j;
    found  = 1'b0;
    rr_idx = '0;
    for (int k = 0; k < N; k++) begin
      j = (int'(ptr_q) + k) % N;
      if (!found && cand[j]) begin
        found  = 1'b1;
        rr_idx = IW'(j);
      end
    end
  end

  assign accept = fill_en && (|cand);
  assign victim = has_free ? free_idx : rr_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      fill_full <= 1'b0;
    end else begin
      fill_full <= fill_en && !(|cand);
      if (accept) ptr_q <= (victim == IW'(N - 1)) ? '0 : victim + 1'b1;
    end
  end

  // R10
  full_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    fill_full |-> $past(fill_en));

  // R7
  no_wired_victim_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> !wired[victim]);

  // R5
  empty_first_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && has_free) |-> !valid[victim]);

endmodule

// File: rtl/tlb_inval_mask.sv
module tlb_inval_mask #(
  parameter int N      = 16,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]             wired,
  input  logic [N-1:0][ASID_W-1:0] asid_tab,
  input  logic                     inv_all,
  input  logic                     inv_asid_en,
  input  logic [ASID_W-1:0]        inv_asid,
  output logic [N-1:0]             clr
);

  for (genvar i = 0; i < N; i++) begin : g_clr
    assign clr[i] = !wired[i] && (inv_all || (inv_asid_en && (asid_tab[i] == inv_asid)));
  end

endmodule

// File: rtl/tlb_asid_xlate.sv
module tlb_asid_xlate #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 16,
  parameter int PERM_W = 3,
  localparam int IDX_W = tlb_pkg::idx_width(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [PERM_W-1:0] lk_perm,
  output logic              lk_multi,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  output logic              fill_full,
  input  logic              pin_en,
  input  logic [IDX_W-1:0]  pin_idx,
  input  logic              pin_set,
  input  logic              inv_all,
  input  logic              inv_asid_en,
  input  logic [ASID_W-1:0] inv_asid
);

  logic [N-1:0]              valid_q;
  logic [N-1:0]              wired_q;
  logic [N-1:0][VPN_W-1:0]   vpn_q;
  logic [N-1:0][ASID_W-1:0]  asid_q;
  logic [N-1:0][PFN_W-1:0]   pfn_q;
  logic [N-1:0][PERM_W-1:0]  perm_q;

  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic              accept;
  logic [IDX_W-1:0]  victim;
  logic [N-1:0]      clr;

  tlb_cam_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
    .valid    (valid_q),
    .vpn_tab  (vpn_q),
    .asid_tab (asid_q),
    .key_vpn  (lk_vpn),
    .key_asid (lk_asid),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .multi    (lk_multi)
  );

  tlb_victim_sel #(.N(N)) u_victim (
    .clk       (clk),
    .rst       (rst),
    .valid     (valid_q),
    .wired     (wired_q),
    .fill_en   (fill_en),
    .accept    (accept),
    .victim    (victim),
    .fill_full (fill_full)
  );

  tlb_inval_mask #(.N(N), .ASID_W(ASID_W)) u_inval (
    .wired       (wired_q),
    .asid_tab    (asid_q),
    .inv_all     (inv_all),
    .inv_asid_en (inv_asid_en),
    .inv_asid    (inv_asid),
    .clr         (clr)
  );

  // Lookup result, forced to zero on a miss
  assign lk_hit  = hit;
  assign lk_pfn  = hit ? pfn_q[hit_idx]  : '0;
  assign lk_perm = hit ? perm_q[hit_idx] : '0;

  // Control state: invalidate first, then the fill sets its own entry
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      wired_q <= '0;
    end else begin
      valid_q <= valid_q & ~clr;
      if (accept) valid_q[victim] <= 1'b1;
      if (pin_en) wired_q[pin_idx] <= pin_set;
    end
  end

  // Translation payload, no reset needed behind the valid bits
  always_ff @(posedge clk) begin
    if (accept) begin
      vpn_q[victim]  <= fill_vpn;
      asid_q[victim] <= fill_asid;
      pfn_q[victim]  <= fill_pfn;
      perm_q[victim] <= fill_perm;
    end
  end

  // R11
  multi_has_hit_chk: assert property (@(posedge clk) disable iff (rst)
    lk_multi |-> lk_hit);

  // R8
  inv_all_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_all && !fill_en && !pin_en) |=> ((valid_q & ~wired_q) == '0));

  for (genvar i = 0; i < N; i++) begin : g_pin_chk
    // R7
    pinned_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wired_q[i] && !(pin_en && pin_idx == IDX_W'(i)))
        |=> (valid_q[i] == $past(valid_q[i])) && $stable(vpn_q[i]) && $stable(asid_q[i]));
  end

endmodule

// File: tb/tlb_asid_xlate_bench.sv
`timescale 1ns/1ps
module tlb_asid_xlate_bench;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] lk_vpn = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_hit;
  logic [15:0] lk_pfn;
  logic [2:0]  lk_perm;
  logic        lk_multi;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [7:0]  fill_asid = '0;
  logic [15:0] fill_pfn = '0;
  logic [2:0]  fill_perm = '0;
  logic        fill_full;
  logic        pin_en = 1'b0;
  logic [3:0]  pin_idx = '0;
  logic        pin_set = 1'b0;
  logic        inv_all = 1'b0;
  logic        inv_asid_en = 1'b0;
  logic [7:0]  inv_asid = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic last_full;

  always #2 clk = ~clk;

  tlb_asid_xlate u_tlb_asid_xlate (
    .clk(clk), .rst(rst),
    .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .lk_perm(lk_perm), .lk_multi(lk_multi),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm), .fill_full(fill_full),
    .pin_en(pin_en), .pin_idx(pin_idx), .pin_set(pin_set),
    .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid)
  );

  typedef struct packed {
    logic        is_fill;
    logic [19:0] vpn;
    logic [7:0]  asid;
    logic [15:0] pfn;
    logic [2:0]  perm;
    logic        ehit;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 20'h00010, 8'd1, 16'h000A, 3'd5, 1'b0},
    '{1'b1, 20'h00020, 8'd1, 16'h000B, 3'd3, 1'b0},
    '{1'b1, 20'h00010, 8'd2, 16'h000C, 3'd1, 1'b0},
    '{1'b0, 20'h00010, 8'd1, 16'h000A, 3'd5, 1'b1},
    '{1'b0, 20'h00010, 8'd2, 16'h000C, 3'd1, 1'b1},
    '{1'b0, 20'h00010, 8'd3, 16'h0000, 3'd0, 1'b0},
    '{1'b0, 20'h00020, 8'd1, 16'h000B, 3'd3, 1'b1},
    '{1'b0, 20'h00020, 8'd2, 16'h0000, 3'd0, 1'b0},
    '{1'b0, 20'h00030, 8'd1, 16'h0000, 3'd0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic do_fill(input logic [19:0] v, input logic [7:0] a,
                         input logic [15:0] p, input logic [2:0] pm);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = v; fill_asid = a; fill_pfn = p; fill_perm = pm;
    @(negedge clk);
    fill_en = 1'b0;
    last_full = fill_full;
  endtask

  task automatic do_pin(input logic [3:0] idx, input logic s);
    @(negedge clk); pin_en = 1'b1; pin_idx = idx; pin_set = s;
    @(negedge clk); pin_en = 1'b0;
  endtask

  task automatic do_inv(input logic all, input logic by_id, input logic [7:0] a);
    @(negedge clk); inv_all = all; inv_asid_en = by_id; inv_asid = a;
    @(negedge clk); inv_all = 1'b0; inv_asid_en = 1'b0;
  endtask

  task automatic look(input string req, input logic [19:0] v, input logic [7:0] a,
                      input logic eh, input logic [15:0] ep, input logic [2:0] epm);
    @(negedge clk); lk_vpn = v; lk_asid = a;
    #1;
    chk(req, lk_hit, eh);
    chk(req, lk_pfn, ep);
    chk(req, lk_perm, epm);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R3: reset state is empty
    look("R3 reset", 20'h00010, 8'd1, 1'b0, 16'h0, 3'd0);
    chk("R3 reset full", fill_full, 1'b0);
    chk("R3 reset multi", lk_multi, 1'b0);

    // R1 R2 R4: vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_fill) do_fill(VEC[i].vpn, VEC[i].asid, VEC[i].pfn, VEC[i].perm);
      else begin
        look("R1 R2 R4 table", VEC[i].vpn, VEC[i].asid, VEC[i].ehit, VEC[i].pfn, VEC[i].perm);
        chk("R11 single", lk_multi, 1'b0);
      end
    end

    // Fill all slots; entry k holds vpn 0x100+k, entry 5 uses identifier 2
    do_reset();
    for (int k = 0; k < N; k++)
      do_fill(20'h100 + 20'(k), (k == 5) ? 8'd2 : 8'd1, 16'h200 + 16'(k), 3'd2);
    look("R4 full set", 20'h10F, 8'd1, 1'b1, 16'h20F, 3'd2);
    // R6: pointer wrapped to 0, entry 0 is the victim
    do_fill(20'h500, 8'd1, 16'h300, 3'd1);
    look("R6 evict0", 20'h100, 8'd1, 1'b0, 16'h0, 3'd0);
    look("R6 keep1", 20'h101, 8'd1, 1'b1, 16'h201, 3'd2);
    look("R6 new", 20'h500, 8'd1, 1'b1, 16'h300, 3'd1);
    // R7: pin entry 1; pointer at 1 skips to entry 2
    do_pin(4'd1, 1'b1);
    do_fill(20'h501, 8'd1, 16'h301, 3'd1);
    look("R7 pinned kept", 20'h101, 8'd1, 1'b1, 16'h201, 3'd2);
    look("R6 evict2", 20'h102, 8'd1, 1'b0, 16'h0, 3'd0);
    // R9: clear identifier 1
    do_inv(1'b0, 1'b1, 8'd1);
    look("R9 other id kept", 20'h105, 8'd2, 1'b1, 16'h205, 3'd2);
    look("R9 cleared", 20'h103, 8'd1, 1'b0, 16'h0, 3'd0);
    look("R9 cleared new", 20'h500, 8'd1, 1'b0, 16'h0, 3'd0);
    look("R7 pinned vs id clear", 20'h101, 8'd1, 1'b1, 16'h201, 3'd2);
    // R5: 14 empty slots are filled before entry 5 is touched
    for (int k = 0; k < 14; k++) do_fill(20'h600 + 20'(k), 8'd1, 16'h400 + 16'(k), 3'd4);
    look("R5 valid untouched", 20'h105, 8'd2, 1'b1, 16'h205, 3'd2);
    look("R5 last fill", 20'h60D, 8'd1, 1'b1, 16'h40D, 3'd4);
    // R6: last empty victim was 15, pointer wraps to entry 0 (vpn 0x600)
    do_fill(20'h700, 8'd1, 16'h500, 3'd6);
    look("R6 wrap evict", 20'h600, 8'd1, 1'b0, 16'h0, 3'd0);
    look("R6 wrap keep", 20'h601, 8'd1, 1'b1, 16'h401, 3'd4);
    // R8: global clear
    do_inv(1'b1, 1'b0, 8'd0);
    look("R8 clear a", 20'h601, 8'd1, 1'b0, 16'h0, 3'd0);
    look("R8 clear b", 20'h105, 8'd2, 1'b0, 16'h0, 3'd0);
    look("R8 pinned kept", 20'h101, 8'd1, 1'b1, 16'h201, 3'd2);
    // R12: fill and global clear on the same edge
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 20'h800; fill_asid = 8'd3; fill_pfn = 16'h0777; fill_perm = 3'd7;
    inv_all = 1'b1;
    @(negedge clk);
    fill_en = 1'b0; inv_all = 1'b0;
    look("R12 fill survives", 20'h800, 8'd3, 1'b1, 16'h0777, 3'd7);
    // R10: pin every entry, then a fill is refused
    for (int k = 0; k < N; k++) do_pin(4'(k), 1'b1);
    do_fill(20'h900, 8'd1, 16'h0999, 3'd1);
    chk("R10 full pulse", last_full, 1'b1);
    @(negedge clk);
    chk("R10 one cycle", fill_full, 1'b0);
    look("R10 not written", 20'h900, 8'd1, 1'b0, 16'h0, 3'd0);
    look("R10 pinned intact", 20'h800, 8'd3, 1'b1, 16'h0777, 3'd7);
    // R7: unpin entry 1; it becomes the only candidate
    do_pin(4'd1, 1'b0);
    do_fill(20'h901, 8'd1, 16'h0901, 3'd3);
    chk("R7 unpin accepted", last_full, 1'b0);
    look("R7 unpinned replaced", 20'h101, 8'd1, 1'b0, 16'h0, 3'd0);
    look("R7 new in slot", 20'h901, 8'd1, 1'b1, 16'h0901, 3'd3);

    // R11: duplicate translations
    do_reset();
    do_fill(20'hAAA, 8'd3, 16'h0011, 3'd1);
    do_fill(20'hAAA, 8'd3, 16'h0022, 3'd2);
    look("R11 lowest wins", 20'hAAA, 8'd3, 1'b1, 16'h0011, 3'd1);
    chk("R11 multi flag", lk_multi, 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule